// File: doc/BRIEF.md
# Frame-Deadline Memory Priority Arbiter

This block decides, every clock cycle, which of two memory requesters gets the single memory slot: a latency-sensitive processor port or a throughput-oriented graphics port. By default the processor port wins every conflict. The graphics side reports each finished screen tile with a one-cycle pulse. The block counts these pulses against the cycles elapsed in the current frame, and it raises the graphics port's standing when the frame is falling behind schedule.

Progress is judged at fixed intervals of 256 cycles. If the tiles finished so far are fewer than a straight-line schedule would require, the two ports share the slot in alternation. If the frame is behind and less than an eighth of the frame time remains, the graphics port wins every conflict. When each frame ends, the counters clear and the processor port regains precedence. The frame length in cycles and the tile count per frame are configuration inputs.

Top module: `mem_prio_arb`

## Requirements
- R1: While `rst` is high, both grants are low. After `rst` falls, the arbiter starts in processor-first mode.
- R2: Grants are registered. A grant is raised in the cycle after a request is sampled, never to a port that did not request, and never to both ports at once. Whenever at least one port requested, one grant follows.
- R3: In processor-first mode, when both ports request, `cpu_gnt` follows.
- R4: In shared mode, when both ports request, the grant goes to the port that was not granted most recently. After reset the graphics port counts as the most recent winner.
- R5: In graphics-first mode, when both ports request, `gpu_gnt` follows.
- R6: The frame counts as late when tiles_done × `cfg_frame_period` < elapsed × `cfg_tiles_per_frame`. Here elapsed is the count of cycles since the frame began. At an evaluation, a frame that is late but not near its deadline selects shared mode, and a frame that is on time selects processor-first mode.
- R7: The deadline is near when `cfg_frame_period` − elapsed < `cfg_frame_period` / 8 (integer). At an evaluation, a frame that is both late and near its deadline selects graphics-first mode.
- R8: An evaluation happens only in the cycle where the low 8 bits of elapsed are all ones. The mode is held unchanged in every other cycle except a frame end. A new mode affects grants from the next cycle on.
- R9: The cycle with elapsed = `cfg_frame_period` − 1 ends the frame. In that cycle elapsed and the tile count clear and the mode returns to processor-first. A tile pulse in that cycle is not counted, and the tile count saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_frame_period | input | CYC_W | Frame length in cycles, at least 2 |
| cfg_tiles_per_frame | input | TILE_W | Tiles that make up a full frame |
| tile_done | input | 1 | One pulse per finished tile |
| cpu_req | input | 1 | Processor port request |
| gpu_req | input | 1 | Graphics port request |
| cpu_gnt | output | 1 | Processor port grant, registered |
| gpu_gnt | output | 1 | Graphics port grant, registered |

## Verification
The properties assume that both configuration inputs stay fixed while the block is out of reset. They also assume that the frame period is at least 2, so that the frame-end comparison never wraps. The bench changes configuration only while reset is held and draws frame periods from a range well above that floor. Tile pulses and requests are random per cycle, and directed cases place tile pulses exactly on and just after a frame boundary.

// File: rtl/mpa_pkg.sv
`timescale 1ns/1ps
package mpa_pkg;
  typedef enum logic [1:0] {
    PM_CPU_FIRST = 2'd0,
    PM_SHARED    = 2'd1,
    PM_GPU_FIRST = 2'd2
  } prio_mode_e;
endpackage

// File: rtl/mpa_frame_track.sv
`timescale 1ns/1ps
module mpa_frame_track #(
  parameter int CYC_W     = 16,
  parameter int TILE_W    = 12,
  parameter int EVAL_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CYC_W-1:0]  cfg_frame_period,
  input  logic              tile_done,
  output logic [CYC_W-1:0]  elapsed,
  output logic [TILE_W-1:0] tiles,
  output logic              frame_end,
  output logic              eval_tick
);
  localparam logic [TILE_W-1:0] TILE_MAX = {TILE_W{1'b1}};
  localparam logic [CYC_W-1:0]  ONE_CYC  = CYC_W'(1);

  // last cycle of the frame; >= keeps the counter bounded
  assign frame_end = (elapsed >= (cfg_frame_period - ONE_CYC));
  // progress sampling point every 2**EVAL_LOG2 cycles of the frame
  assign eval_tick = (&elapsed[EVAL_LOG2-1:0]) && !frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      tiles   <= '0;
    end else if (frame_end) begin
      elapsed <= '0;
      tiles   <= '0;
    end else begin
      elapsed <= elapsed + ONE_CYC;
      if (tile_done && (tiles != TILE_MAX)) begin
        tiles <= tiles + TILE_W'(1);
      end
    end
  end
endmodule

// File: rtl/mpa_mode_eval.sv
`timescale 1ns/1ps
module mpa_mode_eval
  import mpa_pkg::*;
#(
  parameter int CYC_W      = 16,
  parameter int TILE_W     = 12,
  parameter int NEAR_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CYC_W-1:0]  cfg_frame_period,
  input  logic [TILE_W-1:0] cfg_tiles_per_frame,
  input  logic [CYC_W-1:0]  elapsed,
  input  logic [TILE_W-1:0] tiles,
  input  logic              frame_end,
  input  logic              eval_tick,
  output prio_mode_e        mode
);
  localparam int PROD_W = CYC_W + TILE_W;

  logic [PROD_W-1:0] work_done;
  logic [PROD_W-1:0] work_due;
  logic [CYC_W-1:0]  remain;
  logic [CYC_W-1:0]  near_limit;
  logic              late;
  logic              near;
  prio_mode_e        verdict;

  // cross-multiplied progress test avoids any division
  assign work_done  = PROD_W'(tiles) * PROD_W'(cfg_frame_period);
  assign work_due   = PROD_W'(elapsed) * PROD_W'(cfg_tiles_per_frame);
  assign late       = (work_done < work_due);
  assign remain     = cfg_frame_period - elapsed;
  assign near_limit = cfg_frame_period >> NEAR_SHIFT;
  assign near       = (remain < near_limit);

  always_comb begin
    if (!late) begin
      verdict = PM_CPU_FIRST;
    end else if (near) begin
      verdict = PM_GPU_FIRST;
    end else begin
      verdict = PM_SHARED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= PM_CPU_FIRST;
    end else if (frame_end) begin
      mode <= PM_CPU_FIRST;
    end else if (eval_tick) begin
      mode <= verdict;
    end
  end
endmodule

// File: rtl/mpa_grant_sel.sv
`timescale 1ns/1ps
module mpa_grant_sel
  import mpa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  prio_mode_e mode,
  input  logic       cpu_req,
  input  logic       gpu_req,
  output logic       cpu_gnt,
  output logic       gpu_gnt
);
  logic last_gpu;   // most recent winner was the graphics port
  logic pick_cpu;
  logic pick_gpu;

  always_comb begin
    pick_cpu = 1'b0;
    pick_gpu = 1'b0;
    if (cpu_req && gpu_req) begin
      unique case (mode)
        PM_GPU_FIRST: pick_gpu = 1'b1;
        PM_SHARED: begin
          pick_cpu = last_gpu;
          pick_gpu = !last_gpu;
        end
        default: pick_cpu = 1'b1;
      endcase
    end else begin
      pick_cpu = cpu_req;
      pick_gpu = gpu_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_gnt  <= 1'b0;
      gpu_gnt  <= 1'b0;
      last_gpu <= 1'b1;
    end else begin
      cpu_gnt <= pick_cpu;
      gpu_gnt <= pick_gpu;
      if (pick_cpu) begin
        last_gpu <= 1'b0;
      end else if (pick_gpu) begin
        last_gpu <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_prio_arb.sv
`timescale 1ns/1ps
module mem_prio_arb
  import mpa_pkg::*;
#(
  parameter int CYC_W      = 16,
  parameter int TILE_W     = 12,
  parameter int EVAL_LOG2  = 8,
  parameter int NEAR_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CYC_W-1:0]  cfg_frame_period,
  input  logic [TILE_W-1:0] cfg_tiles_per_frame,
  input  logic              tile_done,
  input  logic              cpu_req,
  input  logic              gpu_req,
  output logic              cpu_gnt,
  output logic              gpu_gnt
);
  logic [CYC_W-1:0]  elapsed;
  logic [TILE_W-1:0] tiles;
  logic              frame_end;
  logic              eval_tick;
  prio_mode_e        mode;

  mpa_frame_track #(
    .CYC_W(CYC_W), .TILE_W(TILE_W), .EVAL_LOG2(EVAL_LOG2)
  ) u_track (
    .clk(clk), .rst(rst),
    .cfg_frame_period(cfg_frame_period),
    .tile_done(tile_done),
    .elapsed(elapsed), .tiles(tiles),
    .frame_end(frame_end), .eval_tick(eval_tick)
  );

  mpa_mode_eval #(
    .CYC_W(CYC_W), .TILE_W(TILE_W), .NEAR_SHIFT(NEAR_SHIFT)
  ) u_eval (
    .clk(clk), .rst(rst),
    .cfg_frame_period(cfg_frame_period),
    .cfg_tiles_per_frame(cfg_tiles_per_frame),
    .elapsed(elapsed), .tiles(tiles),
    .frame_end(frame_end), .eval_tick(eval_tick),
    .mode(mode)
  );

  mpa_grant_sel u_sel (
    .clk(clk), .rst(rst), .mode(mode),
    .cpu_req(cpu_req), .gpu_req(gpu_req),
    .cpu_gnt(cpu_gnt), .gpu_gnt(gpu_gnt)
  );
endmodule

// File: rtl/mpa_checks.sv
`timescale 1ns/1ps
module mpa_checks #(
  parameter int CYC_W     = 16,
  parameter int TILE_W    = 12,
  parameter int EVAL_LOG2 = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CYC_W-1:0]  cfg_frame_period,
  input logic              cpu_req,
  input logic              gpu_req,
  input logic              cpu_gnt,
  input logic              gpu_gnt,
  input logic [1:0]        mode,
  input logic [CYC_W-1:0]  elapsed,
  input logic [TILE_W-1:0] tiles
);
  logic at_end;
  logic at_eval;
  assign at_end  = (elapsed >= (cfg_frame_period - CYC_W'(1)));
  assign at_eval = (&elapsed[EVAL_LOG2-1:0]);

  a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
    !(cpu_gnt && gpu_gnt));
  a_r2_cpu_needs_req: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |=> !cpu_gnt);
  a_r2_gpu_needs_req: assert property (@(posedge clk) disable iff (rst)
    !gpu_req |=> !gpu_gnt);
  a_r2_no_idle_slot: assert property (@(posedge clk) disable iff (rst)
    (cpu_req || gpu_req) |=> (cpu_gnt || gpu_gnt));
  a_r3_cpu_first: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && cpu_req && gpu_req) |=> cpu_gnt);
  a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && cpu_req && gpu_req && cpu_gnt) |=> gpu_gnt);
  a_r5_gpu_first: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && cpu_req && gpu_req) |=> gpu_gnt);
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (!at_eval && !at_end) |=> $stable(mode));
  a_r9_frame_clear: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (mode == 2'd0 && tiles == '0 && elapsed == '0));
endmodule

bind mem_prio_arb mpa_checks #(
  .CYC_W(CYC_W), .TILE_W(TILE_W), .EVAL_LOG2(EVAL_LOG2)
) u_checks (
  .clk(clk), .rst(rst), .cfg_frame_period(cfg_frame_period),
  .cpu_req(cpu_req), .gpu_req(gpu_req),
  .cpu_gnt(cpu_gnt), .gpu_gnt(gpu_gnt),
  .mode(mode), .elapsed(elapsed), .tiles(tiles)
);

// File: tb/mem_prio_arb_test.sv
`timescale 1ns/1ps
module mem_prio_arb_test;
  localparam int CW = 16;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] per = CW'(1100);
  logic [TW-1:0] tgt = TW'(16);
  logic          tile = 1'b0;
  logic          creq = 1'b0;
  logic          greq = 1'b0;
  logic          cg;
  logic          gg;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  // reference state, built from the requirements
  int unsigned m_el, m_tl;
  int          m_mode;
  logic        m_cg, m_gg, m_last_gpu;

  always #2.5 clk = ~clk;

  mem_prio_arb uut (
    .clk(clk), .rst(rst),
    .cfg_frame_period(per), .cfg_tiles_per_frame(tgt),
    .tile_done(tile), .cpu_req(creq), .gpu_req(greq),
    .cpu_gnt(cg), .gpu_gnt(gg)
  );

  function automatic int judge(int unsigned e, int unsigned t,
                               int unsigned p, int unsigned n);
    longint unsigned have = longint'(t) * longint'(p);
    longint unsigned due  = longint'(e) * longint'(n);
    if (have >= due) return 0;          // R6 on time
    if ((p - e) < (p >> 3)) return 2;   // R7 late and near
    return 1;                           // R6 late
  endfunction

  function automatic logic [1:0] choose(int md, logic c, logic g, logic lg);
    if (c && g) begin
      if (md == 2) return 2'b01;
      if (md == 1) return lg ? 2'b10 : 2'b01;
      return 2'b10;
    end
    return {c, g};
  endfunction

  always @(posedge clk) begin
    logic [1:0] pk;
    cyc <= rst ? 0 : cyc + 1;
    if (rst) begin
      m_el <= 0; m_tl <= 0; m_mode <= 0;
      m_cg <= 1'b0; m_gg <= 1'b0; m_last_gpu <= 1'b1;
    end else begin
      pk = choose(m_mode, creq, greq, m_last_gpu);
      m_cg <= pk[1];
      m_gg <= pk[0];
      if (pk[1]) m_last_gpu <= 1'b0;
      else if (pk[0]) m_last_gpu <= 1'b1;
      if (m_el >= int'(per) - 1) begin
        m_el <= 0; m_tl <= 0; m_mode <= 0;
      end else begin
        m_el <= m_el + 1;
        if (tile && m_tl < (1 << TW) - 1) m_tl <= m_tl + 1;
        if ((m_el & 255) == 255) m_mode <= judge(m_el, m_tl, per, tgt);
      end
    end
  end

  task automatic chk(string tag, logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  // every cycle: both grants against the reference
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk("R2", cg, m_cg, "cpu_gnt vs model");
      chk("R2", gg, m_gg, "gpu_gnt vs model");
    end
  end

  task automatic do_reset(int p, int n);
    rst = 1'b1;
    per = CW'(p);
    tgt = TW'(n);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_until(int k);
    do @(negedge clk); while (cyc < k);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    // R1: requests held during reset produce no grant
    creq = 1'b1; greq = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", cg, 1'b0, "cpu_gnt in reset");
    chk("R1", gg, 1'b0, "gpu_gnt in reset");
    cmp_en = 1'b1;

    // late frame with no tiles: P=1100, N=16
    do_reset(1100, 16);
    wait_until(1);
    chk("R1", cg, 1'b1, "first grant cpu-first");
    chk("R3", gg, 1'b0, "gpu loses conflict");
    wait_until(256);
    chk("R8", cg, 1'b1, "still cpu-first at eval edge");
    wait_until(257);
    chk("R6", gg, 1'b1, "shared mode first goes to gpu");
    wait_until(258);
    chk("R4", cg, 1'b1, "shared mode alternates to cpu");
    wait_until(259);
    chk("R4", gg, 1'b1, "shared mode alternates to gpu");
    wait_until(1025);
    chk("R7", gg, 1'b1, "near deadline gpu-first");
    wait_until(1026);
    chk("R5", gg, 1'b1, "gpu-first holds");
    wait_until(1101);
    chk("R9", cg, 1'b1, "cpu-first after frame end");
    wait_until(1102);
    chk("R9", cg, 1'b1, "cpu-first persists");

    // single requester in gpu-first mode still served
    wait_until(1100 + 1025 - 1);
    creq = 1'b1; greq = 1'b0;
    wait_until(1100 + 1025);
    chk("R2", cg, 1'b1, "lone cpu served in gpu-first");
    greq = 1'b1;

    // tile on the frame-end cycle is dropped: P=300, N=1
    do_reset(300, 1);
    wait_until(299);
    tile = 1'b1;
    wait_until(300);
    tile = 1'b0;
    wait_until(557);
    chk("R9", gg, 1'b1, "end-cycle tile ignored, shared mode");
    wait_until(558);
    chk("R9", cg, 1'b1, "end-cycle tile ignored, alternation");

    // tile one cycle later is counted: frame on time
    do_reset(300, 1);
    wait_until(300);
    tile = 1'b1;
    wait_until(301);
    tile = 1'b0;
    wait_until(557);
    chk("R6", cg, 1'b1, "counted tile keeps cpu-first");
    wait_until(558);
    chk("R6", cg, 1'b1, "counted tile keeps cpu-first again");

    // random traffic under several configurations
    for (int r = 0; r < 4; r++) begin
      int p    = $urandom_range(400, 1500);
      int n    = $urandom_range(1, 30);
      int tpct = $urandom_range(0, 8);
      do_reset(p, n);
      for (int i = 0; i < 2 * p + 10; i++) begin
        @(negedge clk);
        creq = ($urandom_range(0, 99) < 70);
        greq = ($urandom_range(0, 99) < 70);
        tile = ($urandom_range(0, 99) < tpct);
      end
      tile = 1'b0;
    end

    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule